// File: doc/BRIEF.md
# Stack Pointer and Status Register Unit

This datapath block holds the processor status word (privilege, priority and condition codes) and a saved copy of the user stack pointer. During the trap and interrupt entry sequence it switches the status word to supervisor mode, raises the priority and parks the user stack pointer. During the return sequence it restores each status field from a value popped off the stack and brings the user stack pointer back.

A microsequencer controls it through load strobes and mux selects. The stack register R6 lives in the register file outside this block. The unit receives the current R6, and it produces two things. The first is the candidate next value for R6: the bus, R6 plus two, or the supervisor stack pointer. The second is a stack value for the shared bus: R6 plus two, R6 minus two, or the saved user pointer. A single gated output carries either the status word or that stack value onto the bus.

Top module: `sp_psr_unit`

## Requirements
- R1: After reset the status word reads 0x0002, which is supervisor mode (bit 15 = 0), priority bit 14 = 0 and condition codes bits 2:0 = 010 (Z). The saved user pointer reads 0x0000.
- R2: When `ld_usp` is high at a clock edge, the saved user pointer takes `r6_in`. Otherwise it keeps its value.
- R3: `sp_sel` picks the stack value. 0 gives `r6_in`+2, 1 gives `r6_in`-2, 2 gives the saved user pointer and 3 gives zero.
- R4: `r6_next` is `bus_in` when `r6_sel`=0, `r6_in`+2 when it is 1, `ssp_in` when it is 2, and `r6_in` unchanged when it is 3.
- R5: When `ld_priv` or `ld_psr` is high, bit 15 of the status word loads 0 (forced supervisor) if `priv_sel`=0, or `bus_in[15]` if `priv_sel`=1. Value 1 means user mode.
- R6: When `ld_prio` or `ld_psr` is high, bit 14 loads 1 (forced highest priority) if `prio_sel`=0, or `bus_in[14]` if `prio_sel`=1.
- R7: When `ld_psr` is high, bits 2:0 load `nzp_in` if `cc_sel`=0, or `bus_in[2:0]` if `cc_sel`=1. `ld_priv` or `ld_prio` alone leave the condition codes and the other field unchanged.
- R8: Bits 13:3 of the status word always read zero, even when the popped value has ones there.
- R9: `bus_out` is the status word when `gate_psr` is high. Otherwise it is the stack value when `gate_sp` is high, and zero when neither is high. `gate_psr` wins if both are high.
- R10: Adding and subtracting two wrap modulo 2^16, so 0xFFFF+2 = 0x0001 and 0x0000-2 = 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 16 | Bus value, also the popped status word |
| r6_in | input | 16 | Current stack register R6 |
| ssp_in | input | 16 | Supervisor stack pointer |
| nzp_in | input | 3 | Condition codes from the flag logic |
| ld_usp | input | 1 | Save R6 as the user pointer |
| ld_priv | input | 1 | Load privilege bit |
| ld_prio | input | 1 | Load priority bit |
| ld_psr | input | 1 | Load all status fields |
| priv_sel | input | 1 | 0 forced supervisor, 1 popped bit 15 |
| prio_sel | input | 1 | 0 forced priority 1, 1 popped bit 14 |
| cc_sel | input | 1 | 0 live flags, 1 popped bits 2:0 |
| sp_sel | input | 2 | Stack value select |
| r6_sel | input | 2 | R6 next-value select |
| gate_psr | input | 1 | Drive status word on bus |
| gate_sp | input | 1 | Drive stack value on bus |
| psr_out | output | 16 | Current status word |
| bus_out | output | 16 | Gated bus value |
| r6_next | output | 16 | Candidate next R6 |

## Verification
A wrong privilege, priority or condition-code register shows on `psr_out` one clock after the faulty load. The same wrong value reaches `bus_out` in the cycle `gate_psr` is raised. A corrupted saved user pointer stays hidden until a cycle selects it with `sp_sel`=2 under `gate_sp`, so the bench saves pointers and reads them back at various distances. The pointer arithmetic and the R6 mux are combinational, so an error there is visible in the same cycle on `r6_next` or `bus_out`. The bench compares every output against its model on each clock.

// File: rtl/sp_psr_pkg.sv
package sp_psr_pkg;
    typedef enum logic [1:0] {
        SP_INC  = 2'd0,
        SP_DEC  = 2'd1,
        SP_USP  = 2'd2,
        SP_ZERO = 2'd3
    } sp_sel_e;

    typedef enum logic [1:0] {
        R6_BUS  = 2'd0,
        R6_INC  = 2'd1,
        R6_SSP  = 2'd2,
        R6_HOLD = 2'd3
    } r6_sel_e;
endpackage

// File: rtl/sp_psr_stack.sv
module sp_psr_stack
    import sp_psr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STEP   = 2
) (
    input  logic [DATA_W-1:0] r6_in,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] ssp_in,
    input  logic [DATA_W-1:0] saved_usp,
    input  sp_sel_e           sp_sel,
    input  r6_sel_e           r6_sel,
    output logic [DATA_W-1:0] sp_val,
    output logic [DATA_W-1:0] r6_next
);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic [DATA_W-1:0] r6_inc_d;
    logic [DATA_W-1:0] r6_dec_d;

    always_comb begin
        r6_inc_d = r6_in + STEP_V;
        r6_dec_d = r6_in - STEP_V;
        unique case (sp_sel)
            SP_INC:  sp_val = r6_inc_d;
            SP_DEC:  sp_val = r6_dec_d;
            SP_USP:  sp_val = saved_usp;
            default: sp_val = '0;
        endcase
        unique case (r6_sel)
            R6_BUS:  r6_next = bus_in;
            R6_INC:  r6_next = r6_inc_d;
            R6_SSP:  r6_next = ssp_in;
            default: r6_next = r6_in;
        endcase
    end
endmodule

// File: rtl/sp_psr_usp.sv
module sp_psr_usp #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_usp,
    input  logic [DATA_W-1:0] r6_in,
    output logic [DATA_W-1:0] saved_usp
);
    typedef struct packed {
        logic [DATA_W-1:0] usp;
    } usp_state_t;

    usp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ld_usp) state_d.usp = r6_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign saved_usp = state_q.usp;

    assert_usp_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_usp |=> saved_usp == $past(r6_in));
    assert_usp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_usp |=> $stable(saved_usp));
endmodule

// File: rtl/sp_psr_status.sv
module sp_psr_status #(
    parameter int DATA_W   = 16,
    parameter int PRIV_BIT = 15,
    parameter int PRIO_BIT = 14,
    parameter int CC_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_priv,
    input  logic              ld_prio,
    input  logic              ld_psr,
    input  logic              priv_sel,
    input  logic              prio_sel,
    input  logic              cc_sel,
    input  logic [DATA_W-1:0] pop_val,
    input  logic [CC_W-1:0]   nzp_in,
    output logic [DATA_W-1:0] psr
);
    localparam logic [CC_W-1:0] CC_RESET = CC_W'(2);

    typedef struct packed {
        logic            priv;
        logic            prio;
        logic [CC_W-1:0] cc;
    } psr_state_t;

    psr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ld_priv || ld_psr) state_d.priv = priv_sel ? pop_val[PRIV_BIT] : 1'b0;
        if (ld_prio || ld_psr) state_d.prio = prio_sel ? pop_val[PRIO_BIT] : 1'b1;
        if (ld_psr)            state_d.cc   = cc_sel ? pop_val[CC_W-1:0] : nzp_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.priv <= 1'b0;
            state_q.prio <= 1'b0;
            state_q.cc   <= CC_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        psr                 = '0;
        psr[PRIV_BIT]       = state_q.priv;
        psr[PRIO_BIT]       = state_q.prio;
        psr[CC_W-1:0]       = state_q.cc;
    end

    assert_priv_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_priv || ld_psr) && !priv_sel |=> !psr[PRIV_BIT]);
    assert_prio_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_prio || ld_psr) && !prio_sel |=> psr[PRIO_BIT]);
    assert_cc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_psr |=> $stable(psr[CC_W-1:0]));
    assert_cc_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_psr && cc_sel |=> psr[CC_W-1:0] == $past(pop_val[CC_W-1:0]));
endmodule

// File: rtl/sp_psr_unit.sv
module sp_psr_unit
    import sp_psr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int STEP     = 2,
    parameter int PRIV_BIT = 15,
    parameter int PRIO_BIT = 14,
    parameter int CC_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] r6_in,
    input  logic [DATA_W-1:0] ssp_in,
    input  logic [CC_W-1:0]   nzp_in,
    input  logic              ld_usp,
    input  logic              ld_priv,
    input  logic              ld_prio,
    input  logic              ld_psr,
    input  logic              priv_sel,
    input  logic              prio_sel,
    input  logic              cc_sel,
    input  logic [1:0]        sp_sel,
    input  logic [1:0]        r6_sel,
    input  logic              gate_psr,
    input  logic              gate_sp,
    output logic [DATA_W-1:0] psr_out,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] r6_next
);
    logic [DATA_W-1:0] saved_usp;
    logic [DATA_W-1:0] sp_val;

    sp_psr_usp #(.DATA_W(DATA_W)) i_usp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_usp    (ld_usp),
        .r6_in     (r6_in),
        .saved_usp (saved_usp)
    );

    sp_psr_stack #(.DATA_W(DATA_W), .STEP(STEP)) i_stack (
        .r6_in     (r6_in),
        .bus_in    (bus_in),
        .ssp_in    (ssp_in),
        .saved_usp (saved_usp),
        .sp_sel    (sp_sel_e'(sp_sel)),
        .r6_sel    (r6_sel_e'(r6_sel)),
        .sp_val    (sp_val),
        .r6_next   (r6_next)
    );

    sp_psr_status #(
        .DATA_W(DATA_W), .PRIV_BIT(PRIV_BIT), .PRIO_BIT(PRIO_BIT), .CC_W(CC_W)
    ) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_priv  (ld_priv),
        .ld_prio  (ld_prio),
        .ld_psr   (ld_psr),
        .priv_sel (priv_sel),
        .prio_sel (prio_sel),
        .cc_sel   (cc_sel),
        .pop_val  (bus_in),
        .nzp_in   (nzp_in),
        .psr      (psr_out)
    );

    always_comb begin
        if (gate_psr)     bus_out = psr_out;
        else if (gate_sp) bus_out = sp_val;
        else              bus_out = '0;
    end

    assert_gate_psr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_psr |-> bus_out == psr_out);
    assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_psr && !gate_sp |-> bus_out == '0);
    assert_usp_readout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_psr && gate_sp && sp_sel == 2'd2 && $past(ld_usp) |-> bus_out == $past(r6_in));
endmodule

// File: tb/test_sp_psr_unit.sv
`timescale 1ns/1ps
module test_sp_psr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = '0, r6_in = '0, ssp_in = '0;
    logic [2:0]  nzp_in = '0;
    logic        ld_usp = 0, ld_priv = 0, ld_prio = 0, ld_psr = 0;
    logic        priv_sel = 0, prio_sel = 0, cc_sel = 0;
    logic [1:0]  sp_sel = '0, r6_sel = '0;
    logic        gate_psr = 0, gate_sp = 0;
    logic [15:0] psr_out, bus_out, r6_next;

    int checks = 0, errors = 0;
    bit done = 0;

    int m_priv, m_prio, m_cc, m_usp;

    always #2.5 clk = ~clk;

    sp_psr_unit i_sp_psr_unit (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .r6_in(r6_in), .ssp_in(ssp_in),
        .nzp_in(nzp_in), .ld_usp(ld_usp), .ld_priv(ld_priv), .ld_prio(ld_prio),
        .ld_psr(ld_psr), .priv_sel(priv_sel), .prio_sel(prio_sel), .cc_sel(cc_sel),
        .sp_sel(sp_sel), .r6_sel(r6_sel), .gate_psr(gate_psr), .gate_sp(gate_sp),
        .psr_out(psr_out), .bus_out(bus_out), .r6_next(r6_next)
    );

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int m_psr();
        return (m_priv << 15) | (m_prio << 14) | m_cc;
    endfunction

    function automatic int m_stack();
        case (sp_sel)
            2'd0: return (int'(r6_in) + 2) % 65536;
            2'd1: return (int'(r6_in) + 65534) % 65536;
            2'd2: return m_usp;
            default: return 0;
        endcase
    endfunction

    // Compare all outputs with the model, then clock once and advance the model.
    task automatic step();
        int r6e, buse;
        #1;
        case (r6_sel)
            2'd0: r6e = bus_in;
            2'd1: r6e = (int'(r6_in) + 2) % 65536;
            2'd2: r6e = ssp_in;
            default: r6e = r6_in;
        endcase
        buse = gate_psr ? m_psr() : (gate_sp ? m_stack() : 0);
        chk("R5 R6 R7 R8 psr_out", psr_out, 16'(m_psr()));
        chk("R3 R9 R10 bus_out", bus_out, 16'(buse));
        chk("R4 r6_next", r6_next, 16'(r6e));
        @(posedge clk);
        if (ld_usp) m_usp = r6_in;
        if (ld_priv || ld_psr) m_priv = priv_sel ? bus_in[15] : 0;
        if (ld_prio || ld_psr) m_prio = prio_sel ? bus_in[14] : 1;
        if (ld_psr) m_cc = cc_sel ? bus_in[2:0] : nzp_in;
        @(negedge clk);
    endtask

    task automatic idle();
        ld_usp = 0; ld_priv = 0; ld_prio = 0; ld_psr = 0;
        gate_psr = 0; gate_sp = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_priv = 0; m_prio = 0; m_cc = 2; m_usp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset psr", psr_out, 16'h0002);
        sp_sel = 2'd2; gate_sp = 1; #1;
        chk("R1 reset saved pointer", bus_out, 16'h0000);
        step();

        // R2 save and read back
        idle(); r6_in = 16'h1234; ld_usp = 1; step();
        idle(); r6_in = 16'h5555; sp_sel = 2'd2; gate_sp = 1; #1;
        chk("R2 saved pointer", bus_out, 16'h1234);
        step(); step();
        #1 chk("R2 pointer held", bus_out, 16'h1234);

        // R10 wraparound and R3 selector
        idle(); gate_sp = 1; r6_in = 16'hFFFF; sp_sel = 2'd0; #1;
        chk("R10 increment wrap", bus_out, 16'h0001);
        r6_in = 16'h0000; sp_sel = 2'd1; #1;
        chk("R10 decrement wrap", bus_out, 16'hFFFE);
        sp_sel = 2'd3; #1;
        chk("R3 zero select", bus_out, 16'h0000);
        r6_in = 16'hFFFF; r6_sel = 2'd1; #1;
        chk("R10 r6 increment wrap", r6_next, 16'h0001);
        step();

        // R4 R6 mux
        idle(); ssp_in = 16'h3000; r6_sel = 2'd2; #1;
        chk("R4 ssp select", r6_next, 16'h3000);
        bus_in = 16'hABCD; r6_sel = 2'd0; #1;
        chk("R4 bus select", r6_next, 16'hABCD);
        r6_in = 16'h0042; r6_sel = 2'd3; #1;
        chk("R4 hold select", r6_next, 16'h0042);
        step();

        // R5 R8 popped privilege with ones in unused bits; R7 cc unchanged
        idle(); bus_in = 16'hFFFF; priv_sel = 1; ld_priv = 1; step();
        chk("R5 R7 R8 popped privilege", psr_out, 16'h8002);
        // R6 forced priority
        idle(); prio_sel = 0; ld_prio = 1; step();
        chk("R6 forced priority", psr_out, 16'hC002);
        // R7 whole load from live flags, forced supervisor, popped priority 0
        idle(); bus_in = 16'h0000; nzp_in = 3'b100; priv_sel = 0; prio_sel = 1;
        cc_sel = 0; ld_psr = 1; step();
        chk("R7 live flags load", psr_out, 16'h0004);
        // R7 R8 popped full word
        idle(); bus_in = 16'hFFF9; priv_sel = 1; prio_sel = 1; cc_sel = 1; ld_psr = 1; step();
        chk("R7 R8 popped word", psr_out, 16'hC001);
        // R9 priority of gate_psr
        idle(); gate_psr = 1; gate_sp = 1; sp_sel = 2'd0; #1;
        chk("R9 gate priority", bus_out, 16'hC001);
        step();

        // Mixed stimulus against the model
        for (int i = 0; i < 400; i++) begin
            bus_in = 16'($urandom); r6_in = 16'($urandom); ssp_in = 16'($urandom);
            nzp_in = 3'($urandom);
            ld_usp = ($urandom % 4) == 0; ld_priv = ($urandom % 4) == 0;
            ld_prio = ($urandom % 4) == 0; ld_psr = ($urandom % 5) == 0;
            priv_sel = 1'($urandom); prio_sel = 1'($urandom); cc_sel = 1'($urandom);
            sp_sel = 2'($urandom); r6_sel = 2'($urandom);
            gate_psr = 1'($urandom); gate_sp = 1'($urandom);
            if (i % 10 == 0) r6_in = (i % 20 == 0) ? 16'hFFFF : 16'h0000;
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule